// File: doc/BRIEF.md
# Configurable GPIO Port with Strap-Selected Reset Function

This block is an 8-bit general-purpose I/O port for a microcontroller peripheral bus. Each pin is either handed to an alternate bus-control function or kept as a discrete I/O pin. Three byte-wide registers set this up. The assignment register picks the function of each pin. The direction register sets input or output for I/O pins. The data latch holds the output levels, and reading it returns live pin levels or latched bits. The alternate function has its own per-pin output enable and output value. It also sees the raw pin level of every pin assigned to it.

The power-up function of the port comes from a strap input that is sampled while reset is held. The data latch has no reset value, so software can write it before reset is released and its contents survive a reset. The data latch answers at two byte addresses, and both reach the same storage. A small phase state machine has two states. PH_STRAP is forced whenever reset is sampled high. The transition PH_STRAP -> PH_RUN is taken on the first clock edge at which reset is low, and PH_RUN holds while reset stays low. Writes to the assignment and direction registers are honoured only in PH_RUN. Writes to the data latch are honoured in either state.

Top module: `gpio_strap_port`

## Requirements
- R1: For a pin whose assignment bit is 1, pin_oe and pin_out equal alt_oe and alt_out for that pin, and alt_in carries the raw pin_in level. For a pin whose assignment bit is 0, alt_in is 0.
- R2: Each clock edge with rst high loads the assignment register (address 0x10) with all ones if strap_in is 1, and with all zeros if strap_in is 0.
- R3: The direction register (address 0x11) clears to 0x00 on reset. For a pin with assignment bit 0, pin_oe is 1 exactly when its direction bit is 1.
- R4: For a pin with assignment bit 0 and direction bit 1, pin_out equals the latched data bit. Otherwise, with assignment bit 0, pin_out is 0.
- R5: A read of the data latch returns the synchronised pin level for each pin with assignment 0 and direction 0, and the latched bit for every other pin. bus_rdata takes the read value at the clock edge where bus_rd is sampled high.
- R6: The data latch answers at both 0x14 and 0x15. A write at either address is read back at either address.
- R7: The data latch is not changed by reset. Writes to it are honoured even while rst is high.
- R8: pin_in passes through two flops before the read path. A read sampled at the first or second edge after a pin change returns the old level, and a read sampled at the third edge returns the new level.
- R9: A read of any address other than 0x10, 0x11, 0x14 and 0x15 returns 0x00. A write to such an address changes no register.
- R10: A write to the assignment or direction register in the PH_STRAP state (including the first edge after rst falls) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_in | input | 1 | Strap level sampled during reset for the assignment register |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, updated at the edge that samples bus_rd |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable to the pads |
| pin_out | output | 8 | Per-pin output value to the pads |
| alt_oe | input | 8 | Output enable from the alternate function |
| alt_out | input | 8 | Output value from the alternate function |
| alt_in | output | 8 | Pin levels handed to the alternate function |

## Verification
The assertions take for granted that reset is high from time zero and that strap_in is stable on the edge before reset falls. They also assume bus_wr and bus_rd are sampled only on clock edges, with a settled address. The stimulus drives every input on the falling clock edge and holds reset for several cycles at start-up and again mid-run, with strap_in changed only while reset is high. The only assignment or direction write made in PH_STRAP is placed exactly on the release edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Phase of the port relative to reset
    typedef enum logic [0:0] {
        PH_STRAP = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

    // Register selected by the bus address
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ASSIGN = 2'd1,
        SEL_DIR    = 2'd2,
        SEL_DATA   = 2'd3
    } sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_phase_fsm.sv
module gpio_phase_fsm
    import gpio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase,
    output logic   cfg_wr_en
);
    phase_e phase_nxt;

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_STRAP;
        else     phase <= phase_nxt;
    end

    always_comb begin
        unique case (phase)
            PH_STRAP: phase_nxt = PH_RUN;
            PH_RUN:   phase_nxt = PH_RUN;
            default:  phase_nxt = PH_STRAP;
        endcase
    end

    always_comb begin
        unique case (phase)
            PH_STRAP: cfg_wr_en = 1'b0;
            PH_RUN:   cfg_wr_en = 1'b1;
            default:  cfg_wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int          W          = 8,
    parameter int          AW         = 8,
    parameter logic [AW-1:0] ADDR_ASSIGN = 8'h10,
    parameter logic [AW-1:0] ADDR_DIR    = 8'h11,
    parameter logic [AW-1:0] ADDR_DATA_A = 8'h14,
    parameter logic [AW-1:0] ADDR_DATA_B = 8'h15,
    parameter logic [W-1:0]  LATCH_INIT  = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_in,
    input  logic          cfg_wr_en,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    input  logic          bus_rd,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  asg_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  bus_rdata
);
    sel_e         sel;
    logic [W-1:0] data_view;
    logic [W-1:0] rd_mux;
    logic [W-1:0] latch_r = LATCH_INIT;
    logic [W-1:0] rdata_r = '0;

    always_comb begin
        if      (bus_addr == ADDR_ASSIGN) sel = SEL_ASSIGN;
        else if (bus_addr == ADDR_DIR)    sel = SEL_DIR;
        else if (bus_addr == ADDR_DATA_A || bus_addr == ADDR_DATA_B) sel = SEL_DATA;
        else                              sel = SEL_NONE;
    end

    // Configuration registers: strap load in reset, writes only in run phase
    always_ff @(posedge clk) begin
        if (rst) begin
            asg_q <= {W{strap_in}};
            dir_q <= '0;
        end else if (cfg_wr_en && bus_wr) begin
            if (sel == SEL_ASSIGN) asg_q <= bus_wdata;
            if (sel == SEL_DIR)    dir_q <= bus_wdata;
        end
    end

    // Data latch: no reset, writable at any time
    always_ff @(posedge clk) begin
        if (bus_wr && sel == SEL_DATA) latch_r <= bus_wdata;
    end
    assign latch_q = latch_r;

    // Discrete inputs show the pin, everything else shows the latch
    assign data_view = (~asg_q & ~dir_q & pin_sync) | ((asg_q | dir_q) & latch_r);

    always_comb begin
        unique case (sel)
            SEL_ASSIGN: rd_mux = asg_q;
            SEL_DIR:    rd_mux = dir_q;
            SEL_DATA:   rd_mux = data_view;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (bus_rd) rdata_r <= rd_mux;
    end
    assign bus_rdata = rdata_r;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] asg,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] alt_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] alt_in
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic io_drive;
        assign io_drive   = ~asg[i] & dir[i];
        assign pin_oe[i]  = asg[i] ? alt_oe[i]  : io_drive;
        assign pin_out[i] = asg[i] ? alt_out[i] : (io_drive & latch[i]);
        assign alt_in[i]  = asg[i] & pin_in[i];
    end
endmodule

// File: rtl/gpio_strap_port.sv
module gpio_strap_port
    import gpio_pkg::*;
#(
    parameter int          W           = 8,
    parameter int          AW          = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [AW-1:0] ADDR_ASSIGN = 8'h10,
    parameter logic [AW-1:0] ADDR_DIR    = 8'h11,
    parameter logic [AW-1:0] ADDR_DATA_A = 8'h14,
    parameter logic [AW-1:0] ADDR_DATA_B = 8'h15,
    parameter logic [W-1:0]  LATCH_INIT  = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_in,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    input  logic          bus_rd,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_out,
    input  logic [W-1:0]  alt_oe,
    input  logic [W-1:0]  alt_out,
    output logic [W-1:0]  alt_in
);
    phase_e       phase_q;
    logic         cfg_wr_en;
    logic [W-1:0] pin_sync;
    logic [W-1:0] asg_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] latch_q;

    gpio_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase_q),
        .cfg_wr_en (cfg_wr_en)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_regs #(
        .W(W), .AW(AW),
        .ADDR_ASSIGN(ADDR_ASSIGN), .ADDR_DIR(ADDR_DIR),
        .ADDR_DATA_A(ADDR_DATA_A), .ADDR_DATA_B(ADDR_DATA_B),
        .LATCH_INIT(LATCH_INIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .strap_in  (strap_in),
        .cfg_wr_en (cfg_wr_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .pin_sync  (pin_sync),
        .asg_q     (asg_q),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .bus_rdata (bus_rdata)
    );

    gpio_pin_mux #(.W(W)) u_mux (
        .asg     (asg_q),
        .dir     (dir_q),
        .latch   (latch_q),
        .pin_in  (pin_in),
        .alt_oe  (alt_oe),
        .alt_out (alt_out),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .alt_in  (alt_in)
    );
endmodule

// File: rtl/gpio_strap_port_chk.sv
module gpio_strap_port_chk
    import gpio_pkg::*;
#(
    parameter int          W           = 8,
    parameter int          AW          = 8,
    parameter logic [AW-1:0] ADDR_ASSIGN = 8'h10,
    parameter logic [AW-1:0] ADDR_DIR    = 8'h11,
    parameter logic [AW-1:0] ADDR_DATA_A = 8'h14,
    parameter logic [AW-1:0] ADDR_DATA_B = 8'h15
) (
    input logic          clk,
    input logic          rst,
    input logic          strap_in,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [W-1:0]  bus_wdata,
    input logic          bus_rd,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  pin_oe,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  alt_oe,
    input logic [W-1:0]  alt_out,
    input phase_e        phase_q,
    input logic [W-1:0]  asg_q,
    input logic [W-1:0]  dir_q,
    input logic [W-1:0]  latch_q
);
    logic unmapped;
    assign unmapped = (bus_addr != ADDR_ASSIGN) && (bus_addr != ADDR_DIR) &&
                      (bus_addr != ADDR_DATA_A) && (bus_addr != ADDR_DATA_B);

    AST_ALT_PASS: assert property (@(posedge clk) disable iff (rst)
        (((pin_oe ^ alt_oe) & asg_q) == '0) && (((pin_out ^ alt_out) & asg_q) == '0)); // R1

    AST_STRAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> asg_q == {W{$past(strap_in)}}); // R2

    AST_DIR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> dir_q == '0); // R3

    AST_ALIAS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_DATA_B) |=> latch_q == $past(bus_wdata)); // R6

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && unmapped) |=> bus_rdata == '0); // R9

    AST_STRAP_GUARD: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STRAP && bus_wr && bus_addr == ADDR_DIR) |=> $stable(dir_q)); // R10
endmodule

bind gpio_strap_port gpio_strap_port_chk #(
    .W(W), .AW(AW),
    .ADDR_ASSIGN(ADDR_ASSIGN), .ADDR_DIR(ADDR_DIR),
    .ADDR_DATA_A(ADDR_DATA_A), .ADDR_DATA_B(ADDR_DATA_B)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strap_in  (strap_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .alt_oe    (alt_oe),
    .alt_out   (alt_out),
    .phase_q   (phase_q),
    .asg_q     (asg_q),
    .dir_q     (dir_q),
    .latch_q   (latch_q)
);

// File: tb/gpio_strap_port_tb.sv
module gpio_strap_port_tb;
    localparam logic [7:0] A_ASG  = 8'h10;
    localparam logic [7:0] A_DIR  = 8'h11;
    localparam logic [7:0] A_DATA = 8'h14;
    localparam logic [7:0] A_ALT  = 8'h15;
    localparam logic [7:0] A_NONE = 8'h20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_in = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h3C;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic [7:0] alt_oe = '0;
    logic [7:0] alt_out = '0;
    logic [7:0] alt_in;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    gpio_strap_port u_dut (
        .clk(clk), .rst(rst), .strap_in(strap_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .alt_oe(alt_oe), .alt_out(alt_out), .alt_in(alt_in)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // All driver tasks start and end on a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Scoreboard monitor: compares one registered read result per sampled strobe
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() > 0) check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        wr(A_DATA, 8'h5A);                     // R7 write while reset held
        idle(2);
        rst = 1'b0;                            // R10 write on the release edge
        wr(A_DIR, 8'hFF);
        idle(1);
        rd(A_ASG, 8'h00, "R2 strap=0");
        rd(A_DIR, 8'h00, "R10 dir write in strap phase ignored");
        check(pin_oe, 8'h00, "R3 all inputs after reset");
        rd(A_DATA, 8'h3C, "R5 inputs read pins");

        wr(A_DIR, 8'hF0);
        check(pin_oe, 8'hF0, "R3 oe follows dir");
        check(pin_out, 8'h50, "R4 latch on outputs (R7 reset-time write)");
        rd(A_DATA, 8'h5C, "R5 mixed read");

        wr(A_ALT, 8'hA5);
        rd(A_DATA, 8'hAC, "R6 alias write, primary read");
        check(pin_out, 8'hA0, "R4 new latch value");

        alt_oe = 8'h01; alt_out = 8'h01;
        wr(A_ASG, 8'h81);
        check(pin_oe, 8'h71, "R1 alt oe");
        check(pin_out, 8'h21, "R1 alt out");
        check(alt_in, 8'h00, "R1 alt_in masked");
        rd(A_ALT, 8'hAD, "R5 assigned pins show latch");
        pin_in = 8'h81;
        #1 check(alt_in, 8'h81, "R1 alt_in raw pins");
        idle(3);
        rd(A_DATA, 8'hA1, "R5 pins changed");

        rd(A_NONE, 8'h00, "R9 unmapped read");
        wr(A_NONE, 8'hFF);
        rd(A_ASG, 8'h81, "R9 assign untouched");
        rd(A_DIR, 8'hF0, "R9 dir untouched");
        rd(A_DATA, 8'hA1, "R9 data untouched");

        wr(A_ASG, 8'h00);
        wr(A_DIR, 8'h00);
        idle(2);
        pin_in = 8'h42;
        rd(A_DATA, 8'h81, "R8 first edge old");
        rd(A_DATA, 8'h81, "R8 second edge old");
        rd(A_DATA, 8'h42, "R8 third edge new");

        rst = 1'b1; strap_in = 1'b1;
        idle(4);
        rst = 1'b0;
        idle(2);
        rd(A_ASG, 8'hFF, "R2 strap=1");
        rd(A_DIR, 8'h00, "R3 dir cleared");
        rd(A_DATA, 8'hA5, "R7 latch kept over reset");
        check(pin_oe, 8'h01, "R1 all alt after strap");
        check(pin_out, 8'h01, "R1 alt out after strap");

        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule